// File: doc/BRIEF.md
# Watchdog Monitor Timer with Restart Pulse

This block is a two-stage watchdog down-counter. Software writes a low and a high reload latch. It then sets bit 0 of a control register from 0 to 1. That rising write arms the watchdog and loads the counter from the latches. Every later rising write of the same bit reloads the counter, which is how software refreshes the watchdog. Writing the bit back to 0 does nothing to the timer.

While armed, each pulse on the count-enable input lowers the concatenated {high, low} value by one. The low stage borrows straight into the high stage, with no divide-by-N step between them. A count pulse that arrives when both stages are already zero is a timeout. A timeout holds the active-low restart output low for exactly two system clocks. It also disarms the watchdog, clears the control bit and reloads the counter from the latches, so software must arm it again after the restart.

Top module: `wdt_monitor`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `rst_out_n` high, `armed` low and `count` zero.
- R2: While disarmed, `tick` pulses and writes that do not raise the control bit leave `count` unchanged and cause no restart pulse.
- R3: A write to address 2 with data bit 0 set, while the stored control bit is 0 and no pulse is active, sets `armed` and loads `count` with {high latch, low latch} at the next edge.
- R4: Each later 0-to-1 write of the control bit reloads `count` from the latches. Writing 1 while the bit is already 1 does not reload.
- R5: Writing 0 to the control bit changes neither `count` nor `armed`.
- R6: While armed, each `tick` cycle with a nonzero count lowers `count` by one. The low stage wraps to all ones and borrows one from the high stage when it is zero.
- R7: After a load of value N, the timeout happens on the (N+1)th `tick` cycle.
- R8: `rst_out_n` goes low in the cycle after the timeout edge and stays low for exactly two clock cycles.
- R9: A timeout clears `armed` and the control bit and reloads `count` from the latches. Control writes made while the pulse is active are ignored, so a single 1 write after the pulse arms the watchdog again.
- R10: A write to address 0 stores the low latch and a write to address 1 stores the high latch, each from the low bits of `wr_data`. `count` is unaffected until the next reload.
- R11: A rising control write in the same cycle as a timeout tick wins. The counter reloads, the watchdog stays armed and no pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 low latch, 1 high latch, 2 control |
| wr_data | input | DATA_W | Write data |
| tick | input | 1 | Count enable, one decrement per high cycle |
| rst_out_n | output | 1 | Active-low restart pulse |
| armed | output | 1 | Watchdog armed |
| count | output | HI_W+LO_W | Current {high, low} counter value |

## Verification
The assertions check several rules on every cycle. A rising control write must arm the watchdog and load the latch value. A falling write must leave the timer alone. The counter must stay frozen while disarmed and must fall by exactly one per armed tick. A timeout must pull the restart line low, and every pulse must be exactly two cycles long and end with the watchdog disarmed. Other properties only the bench scenarios can show. The full load-to-timeout distance of N+1 ticks is swept over every value of a 6-bit counter. The bench also confirms that latch writes take effect only at the next reload, that repeated 1 writes do not refresh, that a refresh beats a timeout in the same cycle, and that a write during the pulse is dropped.

// File: rtl/wdt_pkg.sv
// Package: shared register addresses of the watchdog monitor timer.
// Assumes a 2-bit write address bus.
package wdt_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_LATCH_LO = 2'd0,
        REG_LATCH_HI = 2'd1,
        REG_CTRL     = 2'd2
    } wdt_reg_e;
endpackage

// File: rtl/wdt_regs.sv
// Module: reload latches and control bit with 0-to-1 edge detection.
// Assumes LO_W and HI_W are no wider than DATA_W. Compares the written
// bit against the stored bit in the system clock domain. The control
// register is locked while a restart pulse is active.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int LO_W   = 8,
    parameter int HI_W   = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pulse_busy,
    input  logic              clear_ctrl,
    output logic [LO_W-1:0]   latch_lo,
    output logic [HI_W-1:0]   latch_hi,
    output logic              ctrl_bit,
    output logic              arm_rise
);
    logic sel_lo, sel_hi, sel_ctrl;

    // Decode the write strobes; control writes are dropped during a pulse.
    always_comb begin
        sel_lo   = wr_en && (wr_addr == REG_LATCH_LO);
        sel_hi   = wr_en && (wr_addr == REG_LATCH_HI);
        sel_ctrl = wr_en && (wr_addr == REG_CTRL) && !pulse_busy;
        arm_rise = sel_ctrl && wr_data[0] && !ctrl_bit;
    end

    // Hold the low reload latch.
    always_ff @(posedge clk) begin
        if (!rst_n)      latch_lo <= '0;
        else if (sel_lo) latch_lo <= wr_data[LO_W-1:0];
    end

    // Hold the high reload latch.
    always_ff @(posedge clk) begin
        if (!rst_n)      latch_hi <= '0;
        else if (sel_hi) latch_hi <= wr_data[HI_W-1:0];
    end

    // Store the control bit; a timeout clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)          ctrl_bit <= 1'b0;
        else if (clear_ctrl) ctrl_bit <= 1'b0;
        else if (sel_ctrl)   ctrl_bit <= wr_data[0];
    end
endmodule

// File: rtl/wdt_stage.sv
// Module: one loadable down-counting stage of the cascade.
// Assumes load takes priority over decrement. Wraps from zero to all
// ones; the caller handles the borrow into the next stage.
module wdt_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] val,
    output logic         zero
);
    // Load or decrement the stage value.
    always_ff @(posedge clk) begin
        if (!rst_n)    val <= '0;
        else if (load) val <= load_val;
        else if (dec)  val <= val - W'(1);
    end

    // Flag a zero value for borrow and timeout detection.
    always_comb zero = (val == '0);
endmodule

// File: rtl/wdt_pulse.sv
// Module: fixed-length active-low restart pulse generator.
// Assumes fire is a single-cycle strobe. The output goes low in the
// cycle after fire and stays low for PULSE_LEN cycles.
module wdt_pulse #(
    parameter int PULSE_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic rst_out_n,
    output logic busy
);
    localparam int PW = $clog2(PULSE_LEN + 1);

    logic [PW-1:0] remain;

    // Count down the cycles left in the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)              remain <= '0;
        else if (fire)           remain <= PW'(PULSE_LEN);
        else if (remain != '0)   remain <= remain - PW'(1);
    end

    // Drive the pulse from the registered count.
    always_comb begin
        busy      = (remain != '0);
        rst_out_n = !busy;
    end
endmodule

// File: rtl/wdt_monitor.sv
// Module: watchdog monitor timer top level.
// Assumes tick is synchronous to clk. The counter has no prescaler:
// the low stage borrows directly into the high stage. The timer is
// disarmed after reset and after every restart pulse it produces.
module wdt_monitor
    import wdt_pkg::*;
#(
    parameter int LO_W      = 8,
    parameter int HI_W      = 8,
    parameter int DATA_W    = 8,
    parameter int PULSE_LEN = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 tick,
    output logic                 rst_out_n,
    output logic                 armed,
    output logic [HI_W+LO_W-1:0] count
);
    logic [LO_W-1:0] latch_lo, lo_val;
    logic [HI_W-1:0] latch_hi, hi_val;
    logic            ctrl_bit, arm_rise, pulse_busy;
    logic            lo_zero, hi_zero, lo_dec, hi_dec, timeout, reload;
    logic            armed_q;

    wdt_regs #(.LO_W(LO_W), .HI_W(HI_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .pulse_busy (pulse_busy),
        .clear_ctrl (timeout),
        .latch_lo   (latch_lo),
        .latch_hi   (latch_hi),
        .ctrl_bit   (ctrl_bit),
        .arm_rise   (arm_rise)
    );

    // Cascade the stages and detect a timeout; a refresh beats a timeout.
    always_comb begin
        lo_dec  = tick && armed_q;
        hi_dec  = lo_dec && lo_zero;
        timeout = lo_dec && lo_zero && hi_zero && !arm_rise;
        reload  = arm_rise || timeout;
    end

    wdt_stage #(.W(LO_W)) u_lo (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (reload),
        .load_val (latch_lo),
        .dec      (lo_dec),
        .val      (lo_val),
        .zero     (lo_zero)
    );

    wdt_stage #(.W(HI_W)) u_hi (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (reload),
        .load_val (latch_hi),
        .dec      (hi_dec),
        .val      (hi_val),
        .zero     (hi_zero)
    );

    // Track the armed state: set by a rising control write, cleared by timeout.
    always_ff @(posedge clk) begin
        if (!rst_n)        armed_q <= 1'b0;
        else if (timeout)  armed_q <= 1'b0;
        else if (arm_rise) armed_q <= 1'b1;
    end

    wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (timeout),
        .rst_out_n (rst_out_n),
        .busy      (pulse_busy)
    );

    // Expose the state.
    always_comb begin
        armed = armed_q;
        count = {hi_val, lo_val};
    end
endmodule

// File: rtl/wdt_monitor_chk.sv
// Module: assertion checker bound to wdt_monitor.
// Assumes the default two-cycle pulse length.
module wdt_monitor_chk
    import wdt_pkg::*;
#(
    parameter int LO_W = 8,
    parameter int HI_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [1:0]           wr_addr,
    input logic                 wr_bit0,
    input logic                 tick,
    input logic                 rst_out_n,
    input logic                 armed,
    input logic [HI_W+LO_W-1:0] count,
    input logic                 ctrl_bit,
    input logic [LO_W-1:0]      latch_lo,
    input logic [HI_W-1:0]      latch_hi
);
    logic ctrl_wr, rise_wr;
    always_comb begin
        ctrl_wr = wr_en && (wr_addr == REG_CTRL);
        rise_wr = ctrl_wr && wr_bit0 && !ctrl_bit && rst_out_n;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (rst_out_n && !armed && count == '0));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !ctrl_wr) |=> $stable(count));

    // R3
    arm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_wr |=> (armed && count == $past({latch_hi, latch_lo})));

    // R5
    fall_noeffect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wr_bit0 && !tick) |=> ($stable(count) && $stable(armed)));

    // R6
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && tick && count != '0 && !ctrl_wr) |=> (count == $past(count) - 1'b1));

    // R7
    timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && tick && count == '0 && !rise_wr) |=> !rst_out_n);

    // R8
    pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out_n) |=> !rst_out_n);

    // R8
    pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_out_n && $past(!rst_out_n)) |=> rst_out_n);

    // R9
    disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_out_n |-> (!armed && !ctrl_bit));
endmodule

bind wdt_monitor wdt_monitor_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_bit0   (wr_data[0]),
    .tick      (tick),
    .rst_out_n (rst_out_n),
    .armed     (armed),
    .count     (count),
    .ctrl_bit  (ctrl_bit),
    .latch_lo  (latch_lo),
    .latch_hi  (latch_hi)
);

// File: tb/wdt_monitor_tb.sv
module wdt_monitor_tb;
    localparam int LO_W = 3;
    localparam int HI_W = 3;
    localparam int DW   = 8;
    localparam int CW   = LO_W + HI_W;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en;
    logic [1:0]    wr_addr;
    logic [DW-1:0] wr_data;
    logic          tick;
    logic          rst_out_n;
    logic          armed;
    logic [CW-1:0] count;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    wdt_monitor #(.LO_W(LO_W), .HI_W(HI_W), .DATA_W(DW), .PULSE_LEN(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tick(tick), .rst_out_n(rst_out_n),
        .armed(armed), .count(count)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a negedge; drives one write cycle and returns at the next negedge.
    task automatic wr(input logic [1:0] a, input int d);
        wr_en = 1'b1; wr_addr = a; wr_data = DW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_latch(input int v);
        wr(2'd0, v % 8);
        wr(2'd1, v / 8);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int low_seen;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; tick = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 rst_out_n", rst_out_n, 1);
        chk("R1 armed", armed, 0);
        chk("R1 count", count, 0);
        rst_n = 1'b1;

        // R2 / R10: ticks and latch writes while disarmed
        tick = 1'b1;
        low_seen = 0;
        set_latch(21);
        wr(2'd2, 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (!rst_out_n) low_seen++;
        end
        chk("R2 count held", count, 0);
        chk("R2 armed", armed, 0);
        chk("R2 no pulse", low_seen, 0);
        chk("R10 latch no effect", count, 0);
        tick = 1'b0;

        // R3: arm
        wr(2'd2, 1);
        chk("R3 armed", armed, 1);
        chk("R3 loaded", count, 21);

        // R6: decrement with borrow
        for (int k = 1; k <= 9; k++) begin
            tick = 1'b1; @(negedge clk); tick = 1'b0;
            chk("R6 count", count, 21 - k);
        end

        // R10: latch write while armed
        set_latch(1);
        chk("R10 count kept", count, 12);

        // R5: falling write
        wr(2'd2, 0);
        chk("R5 count", count, 12);
        chk("R5 armed", armed, 1);

        // R4: rising reload, then a repeated 1 does nothing
        wr(2'd2, 1);
        chk("R4 reload", count, 1);
        tick = 1'b1; @(negedge clk); tick = 1'b0;
        chk("R4 tick", count, 0);
        wr(2'd2, 1);
        chk("R4 no reload on 1-to-1", count, 0);

        // R11: refresh coincides with timeout tick
        wr(2'd2, 0);
        tick = 1'b1;
        wr(2'd2, 1);
        tick = 1'b0;
        chk("R11 armed", armed, 1);
        chk("R11 reloaded", count, 1);
        chk("R11 no pulse", rst_out_n, 1);
        @(negedge clk);
        chk("R11 no pulse later", rst_out_n, 1);

        wr(2'd2, 0);
        // R7 / R8 / R9: sweep every load value
        for (int n = 0; n < (1 << CW); n++) begin
            int ticks;
            set_latch(n);
            wr(2'd2, 1);
            chk("R9 rearm by single write", armed, 1);
            chk("R3 sweep load", count, n);
            ticks = 0;
            tick = 1'b1;
            while (ticks < 80) begin
                @(negedge clk);
                ticks++;
                if (!rst_out_n) break;
                chk("R6 sweep count", count, n - ticks);
            end
            tick = 1'b0;
            chk("R7 ticks to timeout", ticks, n + 1);
            chk("R9 disarmed", armed, 0);
            chk("R9 reload on timeout", count, n);
            wr(2'd2, 1);
            chk("R8 second low cycle", rst_out_n, 0);
            @(negedge clk);
            chk("R8 released", rst_out_n, 1);
            chk("R9 write in pulse ignored", armed, 0);
            tick = 1'b1; @(negedge clk); tick = 1'b0;
            chk("R2 after pulse held", count, n);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule